// File: doc/BRIEF.md
# Periodic Rate and Interrupt Flag Unit

This unit turns a 32.768 kHz enable pulse into the timing base of a clock-calendar. A 15-stage binary divider counts the enable pulses. A four-bit rate code picks one divider output. That one output drives both a square-wave pin and a periodic event flag. The top divider stage also gives a once-per-second pulse for the calendar logic outside this unit. A three-bit divider-control code runs the chain, holds it at zero, or freezes it.

The unit also owns the interrupt status byte. It holds three sticky event flags (periodic, alarm, update-ended), a control register with their enables and the square-wave enable, and a summary flag. While the summary flag is set, the active-low interrupt request is held low. A read strobe clears the flags when the read ends. Events that come in while the read is active are kept and posted once the read is over.

Top module: `prf_unit`

## Requirements
- R1: With the divider running and one enable pulse per clock, a rate code `c` from 3 to 15 gives a square-wave period of 2^(c-1) pulses. Code 1 gives the same period as code 8 (128 pulses), and code 2 the same as code 9 (256 pulses). From a held (zero) divider, the first rising edge of the square wave shows at the output (P/2)+1 clocks after the run code is applied, where P is the period.
- R2: Rate code 0 selects no tap: the square wave stays low and the periodic flag is never set.
- R3: The periodic flag (status bit 6) is set on every rising edge of the selected tap, whatever its enable is. It becomes visible in the same cycle as the square-wave rising edge.
- R4: While the square-wave enable (control bit 0) is 0, the square-wave output is low.
- R5: Divider-control code 3'b010 runs the chain. Any code 3'b11x holds the chain at zero. Every other code freezes it at its current count.
- R6: When the chain is released from zero by code 3'b010, the one-second pulse `sec_o` appears 16385 clocks later, that is 16384 enable pulses plus one register stage.
- R7: The status byte is laid out as: bit 7 summary, bit 6 periodic, bit 5 alarm, bit 4 update-ended. Bits 3..0 always read 0.
- R8: The summary flag is the OR of each flag ANDed with its enable. The enables are control bit 3 (periodic), bit 2 (alarm) and bit 1 (update). `irq_n_o` is low exactly while the summary flag is 1.
- R9: If a flag is already set when its enable is written to 1, `irq_n_o` goes low in the cycle after the write.
- R10: While `stat_rd_i` is high, the flags are frozen. When it falls, all flags and the summary flag clear, and `irq_n_o` is released.
- R11: Alarm or update events that arrive while the read is high, or in the cycle where it falls, are set in the flags after the read and can raise the interrupt.
- R12: Reset clears the three enables, the three flags, the summary flag and the square-wave enable. It leaves the rate code's effect unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32.768 kHz count enable |
| div_ctl_i | input | 3 | Divider control: 010 run, 11x hold at zero, others freeze |
| rate_i | input | 4 | Rate code selecting the divider tap |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_i | input | 4 | Control data: [3] periodic en, [2] alarm en, [1] update en, [0] square-wave en |
| alarm_ev_i | input | 1 | Alarm match event pulse |
| upd_ev_i | input | 1 | Update-ended event pulse |
| stat_rd_i | input | 1 | Status read strobe, high for the length of the read |
| stat_o | output | 8 | Status byte |
| irq_n_o | output | 1 | Active-low interrupt request |
| sqw_o | output | 1 | Square-wave output |
| sec_o | output | 1 | One-clock pulse per second of divided time |

## Verification
Two functions can meet in the same clock: an incoming event and the end of a status read. The bench provokes this by raising an alarm event in the middle of a read and an update event on the exact clock where the strobe falls. It then expects both flags, and the summary bit they enable, to appear right after the read instead of being cleared by it. A second collision is an enable write landing on a flag that is already set. There, the request must go low one clock after the write. The divider side is judged by counting clocks from release to the first edge and between edges, for every rate code.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned STAT_W = 8;

  // Divider bit whose rising edge defines the rate for a non-zero code.
  function automatic int unsigned tap_index(input logic [RATE_W-1:0] code);
    if (code < 4'd3) return int'(code) + 5;
    else             return int'(code) - 2;
  endfunction
endpackage

// File: rtl/prf_divider.sv
module prf_divider
  import prf_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [2:0]        div_ctl_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqwe_i,
  output logic              sqw_o,
  output logic              per_ev_o,
  output logic              sec_o
);
  localparam int IDX_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] cnt_q;
  logic [IDX_W-1:0]  idx_w;
  logic              run_w, hold_w, tap_w, tap_q, top_q;

  assign run_w  = (div_ctl_i == 3'b010);
  assign hold_w = (div_ctl_i[2:1] == 2'b11);
  assign idx_w  = IDX_W'(tap_index(rate_i));
  assign tap_w  = (rate_i != '0) && cnt_q[idx_w];

  // The chain keeps its count through reset; only the control code moves it.
  always_ff @(posedge clk) begin
    if (hold_w)               cnt_q <= '0;
    else if (run_w && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    tap_q <= tap_w;
    top_q <= cnt_q[STAGES-1];
    if (rst) begin
      sqw_o <= 1'b0;
      sec_o <= 1'b0;
    end else begin
      sqw_o <= sqwe_i & tap_w;
      sec_o <= cnt_q[STAGES-1] & ~top_q;
    end
  end

  assign per_ev_o = tap_w & ~tap_q;

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    hold_w |=> (cnt_q == '0));
  p_stop_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_w && !hold_w) |=> $stable(cnt_q));
  p_sqw_low_r4: assert property (@(posedge clk) disable iff (rst)
    !sqwe_i |=> !sqw_o);
  p_sec_single_r6: assert property (@(posedge clk) disable iff (rst)
    sec_o |=> !sec_o);
endmodule

// File: rtl/prf_flags.sv
module prf_flags
  import prf_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr_i,
  input  logic [NSRC:0]     ctl_i,
  input  logic [NSRC-1:0]   ev_i,
  input  logic              rd_i,
  output logic              sqwe_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_n_o
);
  localparam int ZW = STAT_W - 1 - NSRC;

  logic [NSRC-1:0] en_q, en_d, flg_q, flg_d, pend_q, pend_d;
  logic            irqf_q, rd_q;

  always_comb begin
    en_d = ctl_wr_i ? ctl_i[NSRC:1] : en_q;
    if (rd_i) begin
      flg_d  = flg_q;
      pend_d = pend_q | ev_i;
    end else begin
      flg_d  = rd_q ? (pend_q | ev_i) : (flg_q | ev_i);
      pend_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      sqwe_o  <= 1'b0;
      flg_q   <= '0;
      pend_q  <= '0;
      irqf_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      en_q    <= en_d;
      if (ctl_wr_i) sqwe_o <= ctl_i[0];
      flg_q   <= flg_d;
      pend_q  <= pend_d;
      irqf_q  <= |(flg_d & en_d);
      rd_q    <= rd_i;
    end
  end

  assign stat_o  = {irqf_q, flg_q, {ZW{1'b0}}};
  assign irq_n_o = ~irqf_q;

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> ((flg_q & en_q) != '0));
  p_read_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> $stable(flg_q));
  p_event_held_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_i && ev_i[1]) |=> pend_q[1]);
  p_periodic_set_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_i[NSRC-1] && !rd_i) |=> flg_q[NSRC-1]);
endmodule

// File: rtl/prf_unit.sv
module prf_unit
  import prf_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [2:0]        div_ctl_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctl_wr_i,
  input  logic [3:0]        ctl_i,
  input  logic              alarm_ev_i,
  input  logic              upd_ev_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_n_o,
  output logic              sqw_o,
  output logic              sec_o
);
  logic sqwe_w, per_ev_w;

  prf_divider #(.STAGES(STAGES)) u_div (
    .clk(clk), .rst(rst), .tick_i(tick_i), .div_ctl_i(div_ctl_i),
    .rate_i(rate_i), .sqwe_i(sqwe_w), .sqw_o(sqw_o),
    .per_ev_o(per_ev_w), .sec_o(sec_o)
  );

  prf_flags #(.NSRC(3)) u_flags (
    .clk(clk), .rst(rst), .ctl_wr_i(ctl_wr_i), .ctl_i(ctl_i),
    .ev_i({per_ev_w, alarm_ev_i, upd_ev_i}), .rd_i(stat_rd_i),
    .sqwe_o(sqwe_w), .stat_o(stat_o), .irq_n_o(irq_n_o)
  );
endmodule

// File: tb/tb_prf_unit.sv
module tb_prf_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, tick, ctl_wr, alm, upd, rd;
  logic [2:0] div;
  logic [3:0] rate, ctl;
  logic [7:0] stat;
  logic       irq_n, sqw, sec;

  prf_unit dut (
    .clk(clk), .rst(rst), .tick_i(tick), .div_ctl_i(div), .rate_i(rate),
    .ctl_wr_i(ctl_wr), .ctl_i(ctl), .alarm_ev_i(alm), .upd_ev_i(upd),
    .stat_rd_i(rd), .stat_o(stat), .irq_n_o(irq_n), .sqw_o(sqw), .sec_o(sec)
  );

  int checks = 0;
  int fails  = 0;

  // {rate code, period in enable pulses}
  localparam logic [19:0] VEC [15] = '{
    {4'd1, 16'd128},  {4'd2, 16'd256},  {4'd3, 16'd4},    {4'd4, 16'd8},
    {4'd5, 16'd16},   {4'd6, 16'd32},   {4'd7, 16'd64},   {4'd8, 16'd128},
    {4'd9, 16'd256},  {4'd10, 16'd512}, {4'd11, 16'd1024},{4'd12, 16'd2048},
    {4'd13, 16'd4096},{4'd14, 16'd8192},{4'd15, 16'd16384}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wr = 1'b1; ctl = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_alm();
    alm = 1'b1; @(negedge clk); alm = 1'b0;
  endtask

  task automatic pulse_upd();
    upd = 1'b1; @(negedge clk); upd = 1'b0;
  endtask

  task automatic do_read(input bit mid_ev, input bit end_ev, output logic [7:0] during);
    rd = 1'b1;
    @(negedge clk);
    if (mid_ev) alm = 1'b1;
    @(negedge clk);
    alm = 1'b0;
    during = stat;
    if (end_ev) upd = 1'b1;
    rd = 1'b0;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic first_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sqw && n < 40000);
  endtask

  task automatic full_period(output int m);
    m = 0;
    do begin @(negedge clk); m++; end while (sqw && m < 40000);
    do begin @(negedge clk); m++; end while (!sqw && m < 40000);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, m;
    bit ok;
    logic s0;
    rst = 1'b1; tick = 1'b1; div = 3'b110; rate = 4'd0;
    ctl_wr = 1'b0; ctl = 4'd0; alm = 1'b0; upd = 1'b0; rd = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R12", "status after reset", stat, 0);
    chk("R8", "irq after reset", irq_n, 1);
    chk("R4", "sqw after reset", sqw, 0);

    wr_ctl(4'b0001);
    // R1 R3 R7: table of rate codes and expected periods
    for (int i = 0; i < 15; i++) begin
      rate = VEC[i][19:16];
      div = 3'b110;
      step(2);
      do_read(1'b0, 1'b0, d);
      div = 3'b010;
      first_rise(n);
      chk("R1", $sformatf("first edge code %0d", VEC[i][19:16]), n, int'(VEC[i][15:0]) / 2 + 1);
      chk("R3", "periodic flag with enable off", int'(stat[6]), 1);
      chk("R8", "no irq when periodic disabled", irq_n, 1);
      full_period(m);
      chk("R1", $sformatf("period code %0d", VEC[i][19:16]), m, int'(VEC[i][15:0]));
      chk("R7", "low nibble", int'(stat[3:0]), 0);
    end

    // R2: code zero
    rate = 4'd0; div = 3'b010;
    do_read(1'b0, 1'b0, d);
    ok = 1'b1;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (sqw) ok = 1'b0; end
    chk("R2", "sqw idle for code 0", ok, 1);
    chk("R2", "no periodic flag for code 0", int'(stat[6]), 0);

    // R4: square-wave enable off, periodic flag still set
    rate = 4'd3;
    wr_ctl(4'b0000);
    step(1);
    do_read(1'b0, 1'b0, d);
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sqw) ok = 1'b0; end
    chk("R4", "sqw low with enable off", ok, 1);
    chk("R3", "periodic flag with sqw off", int'(stat[6]), 1);
    wr_ctl(4'b0001);
    step(10);

    // R5: freeze, hold, release
    div = 3'b000;
    step(2);
    s0 = sqw; ok = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sqw != s0) ok = 1'b0; end
    chk("R5", "freeze on 000", ok, 1);
    div = 3'b111;
    step(2);
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sqw) ok = 1'b0; end
    chk("R5", "hold on 111", ok, 1);
    div = 3'b011;
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sqw) ok = 1'b0; end
    chk("R5", "freeze on 011 from zero", ok, 1);
    div = 3'b010;
    first_rise(n);
    chk("R5", "first edge after run", n, 3);

    // R6: first one-second pulse
    rate = 4'd0; div = 3'b110;
    step(2);
    div = 3'b010;
    n = 0;
    do begin @(negedge clk); n++; end while (!sec && n < 20000);
    chk("R6", "clocks to first second pulse", n, 16385);

    // Interrupt path with divider frozen
    div = 3'b000;
    wr_ctl(4'b0000);
    do_read(1'b0, 1'b0, d);
    pulse_alm();
    chk("R7", "alarm flag at bit 5", stat, 8'h20);
    chk("R8", "no irq with alarm disabled", irq_n, 1);
    wr_ctl(4'b0100);
    chk("R9", "irq next clock after enable", irq_n, 0);
    chk("R8", "summary bit set", stat, 8'hA0);
    do_read(1'b0, 1'b0, d);
    chk("R10", "status during read", d, 8'hA0);
    chk("R10", "status cleared after read", stat, 0);
    chk("R10", "irq released after read", irq_n, 1);
    do_read(1'b1, 1'b1, d);
    chk("R10", "frozen during read", d, 0);
    chk("R11", "events posted after read", stat, 8'hB0);
    chk("R11", "irq from posted alarm", irq_n, 0);
    do_read(1'b0, 1'b0, d);
    wr_ctl(4'b0010);
    pulse_alm();
    chk("R8", "alarm alone with update enable", irq_n, 1);
    pulse_upd();
    chk("R8", "update raises irq", irq_n, 0);
    chk("R8", "status with update", stat, 8'hB0);
    do_read(1'b0, 1'b0, d);
    rate = 4'd3; div = 3'b010;
    wr_ctl(4'b1000);
    n = 0;
    do begin @(negedge clk); n++; end while (irq_n && n < 20);
    chk("R8", "periodic irq when enabled", irq_n, 0);

    // R12: reset clears control and flags, keeps rate
    div = 3'b000;
    wr_ctl(4'b1111);
    pulse_alm();
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    step(1);
    chk("R12", "status cleared by reset", stat, 0);
    chk("R12", "irq released by reset", irq_n, 1);
    chk("R12", "sqw cleared by reset", sqw, 0);
    pulse_alm();
    chk("R12", "alarm enable cleared", irq_n, 1);
    chk("R12", "flag still settable", stat, 8'h20);
    div = 3'b110;
    step(2);
    wr_ctl(4'b0001);
    div = 3'b010;
    first_rise(n);
    chk("R12", "rate kept through reset", n, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule